// File: doc/BRIEF.md
# Interrupt Controller Indirect Register Window

This block is the register-access front end of an interrupt routing controller. Software reaches every internal register through two bus-visible locations. The first is a select register that holds a register index. The second is a 32-bit data window that reads or writes whichever register the index names. The reachable registers are:

- a controller ID register,
- a read-only version register,
- an arbitration register that mirrors the ID,
- a table of 64-bit redirection entries, one per interrupt pin. Each entry is reached as two 32-bit halves.

When software writes an entry, the writable bits take the new data. The two status bits owned by the delivery engine keep their values. Any entry that ends up edge-triggered has its remote-request bit cleared. A one-cycle service request then goes to the delivery engine.

The delivery engine is a separate block. It sets the status bits through a small update port. It reads any entry through a combinational peek port.

Top module: `intc_regwin`

## Requirements
- R1: Only the low 8 bits of `bus_addr` are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. Any other low byte reads as zero and ignores writes. Higher address bits alias.
- R2: A read of the select register, of any size, returns the full 32-bit value last written to it. A write of any size stores `bus_wdata`.
- R3: A window access whose `bus_size` (a byte count) is not 4 is ignored. Such a read returns zero. Such a write changes no state and raises no service request.
- R4: A window write with select index 0x00 stores `bus_wdata[27:24]` as the ID. Window reads at index 0x00 (ID) and index 0x02 (arbitration) both return the ID in bits [27:24], with zeros elsewhere.
- R5: A window read at index 0x01 returns 0x20 in bits [7:0] and NUM_PINS-1 in bits [23:16]. Writes at index 0x01 or 0x02 are ignored.
- R6: For a select value s ≥ 0x10, the entry is (s-0x10)>>1. An odd s addresses entry bits [63:32] and an even s addresses bits [31:0]. An entry number of NUM_PINS or more, or any other unassigned index, reads as zero and ignores writes.
- R7: Entry bit 14 (remote request) and bit 12 (delivery status) are read-only to the bus. A table write keeps their previous values. The status port (`st_we`, `st_idx`, `st_rirr`, `st_dstat`) is the only way to set them.
- R8: After a table write, if entry bit 15 (trigger mode, 1 = level, 0 = edge) is 0, bit 14 of that entry reads 0.
- R9: `svc_req` is high for exactly the one cycle after each accepted in-range table write. It stays low after any other access.
- R10: The read result appears on `bus_rdata` one cycle after the read strobe. It holds until the next read.
- R11: After reset, the select register and the ID are zero. Every entry is 0x0000_0000_0001_0000, which has the mask bit (bit 16) set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits [7:0] are decoded |
| bus_size | input | 3 | Access size in bytes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| svc_req | output | 1 | Service request pulse to the delivery engine |
| st_we | input | 1 | Status update strobe from the delivery engine |
| st_idx | input | IDX_W | Entry number for the status update |
| st_rirr | input | 1 | New remote-request bit value |
| st_dstat | input | 1 | New delivery-status bit value |
| peek_idx | input | IDX_W | Entry number for the peek port |
| peek_entry | output | 64 | Combinational contents of the selected entry |

## Verification
Bus writes take effect at the strobe edge. A window access in the following cycle already decodes the new select value. Read data is registered, so it is due exactly one cycle after the strobe. The bench queues each expected read value when it issues the strobe. A monitor flags the strobe at that edge and compares the value at the next falling edge. `svc_req` is also registered, so each write task samples it at the falling edge after the write edge. That is the only cycle in which the pulse may be high.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;
  localparam logic [7:0]  OFF_SEL   = 8'h00;
  localparam logic [7:0]  OFF_WIN   = 8'h10;
  localparam logic [31:0] IDX_ID    = 32'h00;
  localparam logic [31:0] IDX_VER   = 32'h01;
  localparam logic [31:0] IDX_ARB   = 32'h02;
  localparam logic [31:0] TBL_BASE  = 32'h10;
  localparam logic [7:0]  VER_CODE  = 8'h20;
  localparam int          ID_LSB    = 24;
  localparam int          ID_W      = 4;
  localparam int          NENT_LSB  = 16;
  localparam int          DSTAT_BIT = 12;
  localparam int          RIRR_BIT  = 14;
  localparam int          TRIG_BIT  = 15;
  localparam int          MASK_BIT  = 16;
  localparam logic [63:0] RO_MASK   = (64'd1 << RIRR_BIT) | (64'd1 << DSTAT_BIT);
  localparam logic [63:0] ENT_RST   = 64'd1 << MASK_BIT;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SEL  = 2'd1,
    TGT_WIN  = 2'd2
  } tgt_e;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import intc_regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [7:0]       addr_lo,
  input  logic [2:0]       size,
  input  logic [31:0]      sel,
  output tgt_e             tgt,
  output logic             size_ok,
  output logic             is_id,
  output logic             is_ver,
  output logic             is_arb,
  output logic             tbl_hit,
  output logic             tbl_hi,
  output logic [IDX_W-1:0] tbl_idx
);
  logic [31:0] off;

  always_comb begin
    if (addr_lo == OFF_SEL)      tgt = TGT_SEL;
    else if (addr_lo == OFF_WIN) tgt = TGT_WIN;
    else                         tgt = TGT_NONE;
  end

  assign size_ok = (size == 3'd4);
  assign is_id   = (sel == IDX_ID);
  assign is_ver  = (sel == IDX_VER);
  assign is_arb  = (sel == IDX_ARB);

  assign off     = sel - TBL_BASE;
  assign tbl_hit = (sel >= TBL_BASE) && ({1'b0, off[31:1]} < 32'(NUM_PINS));
  assign tbl_hi  = sel[0];
  assign tbl_idx = off[IDX_W:1];
endmodule

// File: rtl/regwin_table.sv
module regwin_table
  import intc_regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             st_we,
  input  logic [IDX_W-1:0] st_idx,
  input  logic             st_rirr,
  input  logic             st_dstat,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_entry,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [63:0]      peek_entry
);
  logic [63:0] ent_q [NUM_PINS];
  logic [63:0] ent_d [NUM_PINS];
  logic        ent_en [NUM_PINS];

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_ent
    logic        wr_hit;
    logic        st_hit;
    logic [63:0] ro_src;
    logic [63:0] merged;

    assign wr_hit = wr_en && (wr_idx == IDX_W'(gi));
    assign st_hit = st_we && (st_idx == IDX_W'(gi));

    always_comb begin
      ro_src = ent_q[gi];
      if (st_hit) begin
        ro_src[RIRR_BIT]  = st_rirr;
        ro_src[DSTAT_BIT] = st_dstat;
      end
      merged = wr_hi ? {wr_data, ent_q[gi][31:0]} : {ent_q[gi][63:32], wr_data};
      if (wr_hit) begin
        ent_d[gi] = (merged & ~RO_MASK) | (ro_src & RO_MASK);
        if (!ent_d[gi][TRIG_BIT]) ent_d[gi][RIRR_BIT] = 1'b0;
      end else begin
        ent_d[gi] = ro_src;
      end
      ent_en[gi] = wr_hit || st_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ent_q[gi] <= ENT_RST;
      else if (ent_en[gi]) ent_q[gi] <= ent_d[gi];
    end

    AST_EDGE_RIRR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_hit) && !ent_q[gi][TRIG_BIT]) |-> !ent_q[gi][RIRR_BIT]); // R8

    AST_DSTAT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_hit && !st_hit) |-> (ent_q[gi][DSTAT_BIT] == $past(ent_q[gi][DSTAT_BIT]))); // R7
  end

  assign rd_entry   = ent_q[rd_idx];
  assign peek_entry = ent_q[peek_idx];
endmodule

// File: rtl/regwin_rdmux.sv
module regwin_rdmux
  import intc_regwin_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  tgt_e             tgt,
  input  logic             size_ok,
  input  logic             is_id,
  input  logic             is_ver,
  input  logic             is_arb,
  input  logic             tbl_hit,
  input  logic             tbl_hi,
  input  logic [31:0]      sel,
  input  logic [ID_W-1:0]  id,
  input  logic [63:0]      entry,
  output logic [31:0]      rd_val
);
  localparam logic [7:0] MAX_ENT = 8'(NUM_PINS - 1);

  always_comb begin
    rd_val = '0;
    unique case (tgt)
      TGT_SEL: rd_val = sel;
      TGT_WIN: begin
        if (size_ok) begin
          if (is_id || is_arb)  rd_val = 32'(id) << ID_LSB;
          else if (is_ver)      rd_val = (32'(MAX_ENT) << NENT_LSB) | 32'(VER_CODE);
          else if (tbl_hit)     rd_val = tbl_hi ? entry[63:32] : entry[31:0];
        end
      end
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
  import intc_regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 12,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              svc_req,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic              st_rirr,
  input  logic              st_dstat,
  input  logic [IDX_W-1:0]  peek_idx,
  output logic [63:0]       peek_entry
);
  tgt_e             tgt;
  logic             size_ok, is_id, is_ver, is_arb, tbl_hit, tbl_hi;
  logic [IDX_W-1:0] tbl_idx;
  logic [31:0]      sel_q, sel_d;
  logic             sel_en;
  logic [ID_W-1:0]  id_q, id_d;
  logic             id_en;
  logic [31:0]      rdata_q, rd_val;
  logic             svc_q, svc_d;
  logic             tbl_wr;
  logic [63:0]      rd_entry;
  logic             win_ok;
  logic             unused_addr;

  assign unused_addr = ^bus_addr[ADDR_W-1:8];

  regwin_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .addr_lo (bus_addr[7:0]),
    .size    (bus_size),
    .sel     (sel_q),
    .tgt     (tgt),
    .size_ok (size_ok),
    .is_id   (is_id),
    .is_ver  (is_ver),
    .is_arb  (is_arb),
    .tbl_hit (tbl_hit),
    .tbl_hi  (tbl_hi),
    .tbl_idx (tbl_idx)
  );

  assign win_ok = (tgt == TGT_WIN) && size_ok;
  assign tbl_wr = bus_wr && win_ok && tbl_hit;

  regwin_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_wr),
    .wr_hi      (tbl_hi),
    .wr_idx     (tbl_idx),
    .wr_data    (bus_wdata),
    .st_we      (st_we),
    .st_idx     (st_idx),
    .st_rirr    (st_rirr),
    .st_dstat   (st_dstat),
    .rd_idx     (tbl_idx),
    .rd_entry   (rd_entry),
    .peek_idx   (peek_idx),
    .peek_entry (peek_entry)
  );

  regwin_rdmux #(.NUM_PINS(NUM_PINS)) u_mux (
    .tgt     (tgt),
    .size_ok (size_ok),
    .is_id   (is_id),
    .is_ver  (is_ver),
    .is_arb  (is_arb),
    .tbl_hit (tbl_hit),
    .tbl_hi  (tbl_hi),
    .sel     (sel_q),
    .id      (id_q),
    .entry   (rd_entry),
    .rd_val  (rd_val)
  );

  // next-state
  always_comb begin
    sel_en = bus_wr && (tgt == TGT_SEL);
    sel_d  = bus_wdata;
    id_en  = bus_wr && win_ok && is_id;
    id_d   = bus_wdata[ID_LSB +: ID_W];
    svc_d  = tbl_wr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      id_q    <= '0;
      rdata_q <= '0;
      svc_q   <= 1'b0;
    end else begin
      if (sel_en) sel_q   <= sel_d;
      if (id_en)  id_q    <= id_d;
      if (bus_rd) rdata_q <= rd_val;
      svc_q <= svc_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign svc_req   = svc_q;

  AST_BADSIZE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && (bus_addr[7:0] == OFF_WIN) && (bus_size != 3'd4)) |-> (bus_rdata == 32'd0)); // R3

  AST_SVC_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(bus_wr && (bus_addr[7:0] == OFF_WIN))); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R10

  AST_VER_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && (bus_addr[7:0] == OFF_WIN) && (bus_size == 3'd4) && (sel_q == IDX_VER))
    |-> (bus_rdata == ((32'(NUM_PINS - 1) << 16) | 32'h20))); // R5
endmodule

// File: tb/sim_intc_regwin.sv
module sim_intc_regwin;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 24;
  localparam int IW    = 5;

  logic        clk, rst_n;
  logic [11:0] bus_addr;
  logic [2:0]  bus_size;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        svc_req;
  logic        st_we, st_rirr, st_dstat;
  logic [IW-1:0] st_idx, peek_idx;
  logic [63:0] peek_entry;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        due;

  intc_regwin #(.NUM_PINS(NPINS), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .svc_req(svc_req), .st_we(st_we), .st_idx(st_idx), .st_rirr(st_rirr),
    .st_dstat(st_dstat), .peek_idx(peek_idx), .peek_entry(peek_entry)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: the read strobe is seen at the edge, data compared at the next falling edge
  always @(posedge clk) due <= bus_rd;
  always @(negedge clk) begin
    if (due === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R10: unexpected read result %h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), {32'd0, bus_rdata}, {32'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] sz,
                    input logic exp_svc, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk({tag, " svc"}, {63'd0, svc_req}, {63'd0, exp_svc});
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] sz,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wsel(input logic [31:0] v);
    wr(12'h000, v, 3'd4, 1'b0, "R2 select write");
  endtask

  task automatic stat(input logic [IW-1:0] i, input logic r, input logic d);
    @(negedge clk);
    st_we = 1'b1; st_idx = i; st_rirr = r; st_dstat = d;
    @(negedge clk);
    st_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_size = 3'd4; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; st_we = 1'b0; st_idx = '0; st_rirr = 1'b0; st_dstat = 1'b0;
    peek_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(12'h000, 3'd4, 32'h0, "R11 select after reset");
    rd(12'h010, 3'd4, 32'h0, "R11 ID after reset");
    wsel(32'h10);
    rd(12'h010, 3'd4, 32'h0001_0000, "R11 entry0 low after reset");
    peek_idx = 5'd7; #1;
    chk("R11 peek entry7", peek_entry, 64'h0000_0000_0001_0000);

    // R2 select readback, any size
    wsel(32'h1234_5678);
    rd(12'h000, 3'd1, 32'h1234_5678, "R2 select readback");

    // R5 version
    wsel(32'h01);
    rd(12'h010, 3'd4, 32'h0017_0020, "R5 version value");
    wr(12'h010, 32'hFFFF_FFFF, 3'd4, 1'b0, "R5 version write");
    rd(12'h010, 3'd4, 32'h0017_0020, "R5 version unchanged");

    // R4 ID / arbitration
    wsel(32'h00);
    wr(12'h010, 32'hA5A5_A5A5, 3'd4, 1'b0, "R4 ID write");
    rd(12'h010, 3'd4, 32'h0500_0000, "R4 ID read");
    wsel(32'h02);
    wr(12'h010, 32'hFFFF_FFFF, 3'd4, 1'b0, "R5 arb write");
    rd(12'h010, 3'd4, 32'h0500_0000, "R4 arb read mirrors ID");

    // R6 / R7 / R9 table halves, entry 3
    wsel(32'h16);
    wr(12'h010, 32'h0000_B031, 3'd4, 1'b1, "R9 table low write");
    rd(12'h010, 3'd4, 32'h0000_A031, "R7 low half, dstat not writable");
    wsel(32'h17);
    wr(12'h010, 32'hFF00_0000, 3'd4, 1'b1, "R9 table high write");
    rd(12'h010, 3'd4, 32'hFF00_0000, "R6 high half");
    wsel(32'h16);
    rd(12'h010, 3'd4, 32'h0000_A031, "R6 low half kept");

    // R7 status bits kept across bus writes
    stat(5'd3, 1'b1, 1'b1);
    rd(12'h010, 3'd4, 32'h0000_F031, "R7 status bits set");
    wr(12'h010, 32'h0000_8000, 3'd4, 1'b1, "R9 level rewrite");
    rd(12'h010, 3'd4, 32'h0000_D000, "R7 ro bits kept on level write");

    // R8 edge clears remote request
    wr(12'h010, 32'h0000_0042, 3'd4, 1'b1, "R9 edge rewrite");
    rd(12'h010, 3'd4, 32'h0000_1042, "R8 edge clears remote request");
    peek_idx = 5'd3; #1;
    chk("R8 peek entry3", peek_entry, 64'hFF00_0000_0000_1042);

    // R3 bad size
    rd(12'h010, 3'd2, 32'h0, "R3 size2 read zero");
    wr(12'h010, 32'h0000_FFFF, 3'd1, 1'b0, "R3 size1 write");
    rd(12'h010, 3'd4, 32'h0000_1042, "R3 entry unchanged");

    // R6 last entry and out of range
    wsel(32'h3E);
    wr(12'h010, 32'h0000_8077, 3'd4, 1'b1, "R6 last entry write");
    rd(12'h010, 3'd4, 32'h0000_8077, "R6 last entry low");
    wsel(32'h3F);
    wr(12'h010, 32'hAB00_0000, 3'd4, 1'b1, "R6 last entry high write");
    rd(12'h010, 3'd4, 32'hAB00_0000, "R6 last entry high");
    wsel(32'h40);
    wr(12'h010, 32'hFFFF_FFFF, 3'd4, 1'b0, "R6 out-of-range write");
    rd(12'h010, 3'd4, 32'h0, "R6 out-of-range read zero");
    wsel(32'h03);
    rd(12'h010, 3'd4, 32'h0, "R6 unassigned index read zero");

    // R1 low-byte decode with aliasing, other offsets
    wr(12'h700, 32'h0000_0016, 3'd4, 1'b0, "R1 aliased select write");
    rd(12'h310, 3'd4, 32'h0000_1042, "R1 aliased window read");
    rd(12'h020, 3'd4, 32'h0, "R1 unused offset read zero");
    wr(12'h020, 32'h0000_0000, 3'd4, 1'b0, "R1 unused offset write");
    rd(12'h000, 3'd4, 32'h0000_0016, "R1 select unchanged");

    // R10 hold
    @(negedge clk);
    chk("R10 rdata holds", {32'd0, bus_rdata}, {32'd0, 32'h0000_0016});

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R10: actual %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule